// File: doc/BRIEF.md
# Paged Address Translation Unit

This block lets a narrow-address host controller reach a much larger DRAM. A small page table of sixteen 16-bit entries is visible to the host as a 32-byte window of control addresses. The host fills each entry one byte at a time and can read any byte back over its 8-bit data bus. For every other access, the top four host address bits pick a table entry. That entry's page number is placed above the twelve low host address bits to form a 28-bit physical address.

The physical address is then presented on a 14-bit address pin bus. The pins are loaded from one of four sources: the row half of the physical address, the column half, the low host address bits (used as a disk register address), or all zeros (used during disk DMA). The pin bus is registered and changes only when a load is requested. The table itself has no reset, so software fills it before first use. The pin register clears on reset.

Top module: `pat_top`

## Requirements
- R1: The table has 16 entries of 16 bits at host addresses 0xFF00 to 0xFF1F. Host address bits [4:1] give the entry number. Bit 0 picks the byte: 0 is the low byte [7:0] and 1 is the high byte [15:8].
- R2: When `host_wr` is high and the address is in the window, the rising clock edge writes `host_wdata` into the selected byte of the selected entry. The other byte of that entry keeps its value.
- R3: When `host_rd` is high and the address is in the window, `host_rdata` shows the selected byte of the selected entry in the same cycle, with no clock edge in between.
- R4: A write to an address outside the window does not change any table entry.
- R5: `host_rdata` is zero whenever `host_rd` is low or the address is outside the window.
- R6: For an address outside the window, `phys_addr` equals {entry[host_addr[15:12]], host_addr[11:0]} in the same cycle.
- R7: For an address inside the window, the entry index is taken from host_addr[4:1] instead of [15:12]. `phys_addr` then carries that entry's page number above host_addr[11:0].
- R8: When `pin_ld` is high, the next rising edge loads `addr_pins` according to `pin_mode`. Mode 0 loads phys_addr[27:14] (the row half). Mode 1 loads phys_addr[13:0] (the column half).
- R9: When `pin_ld` is high, mode 2 loads host_addr[13:0] into `addr_pins` at the next rising edge. Mode 3 loads all zeros.
- R10: `addr_pins` is zero after reset and holds its value while `pin_ld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for the pin register |
| host_addr | input | 16 | Host address bus |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Table readback byte, zero when not selected |
| pin_ld | input | 1 | Load enable for the address pin register |
| pin_mode | input | 2 | Pin source: 0 row, 1 column, 2 host register address, 3 zero |
| phys_addr | output | 28 | Translated physical DRAM address |
| addr_pins | output | 14 | Registered address pin bus |

## Verification
A byte written to the wrong entry or the wrong half shows up on the next in-window read. That read happens one cycle after the write, and the bad value appears on `host_rdata` in that same cycle. The same bad table state is also visible right away on `phys_addr` for any translated address that selects the affected entry. A wrong pin source or a pin register that fails to hold is visible on `addr_pins` one edge after the load request. The bench checks that edge directly against the row and column split of its own model of the physical address.

// File: rtl/pat_pkg.sv
package pat_pkg;
  typedef enum logic [1:0] {
    PIN_ROW  = 2'd0,
    PIN_COL  = 2'd1,
    PIN_IDE  = 2'd2,
    PIN_ZERO = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/pat_map_table.sv
module pat_map_table #(
  parameter int ENTRY_CNT = 16,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(ENTRY_CNT),
  localparam int PAGE_W   = 2 * DATA_W
) (
  input  logic                        clk,
  input  logic                        wr_lo,
  input  logic                        wr_hi,
  input  logic [IDX_W-1:0]            idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic [PAGE_W-1:0]           entry,
  output logic [ENTRY_CNT*PAGE_W-1:0] tbl_flat
);
  logic [PAGE_W-1:0] mem [ENTRY_CNT];

  for (genvar g = 0; g < ENTRY_CNT; g++) begin : g_ent
    logic sel;
    logic en_lo, en_hi;
    assign sel   = (idx == IDX_W'(g));
    assign en_lo = sel && wr_lo;
    assign en_hi = sel && wr_hi;

    always_ff @(posedge clk) begin
      if (en_lo) mem[g][DATA_W-1:0] <= wdata;
      if (en_hi) mem[g][PAGE_W-1:DATA_W] <= wdata;
    end

    assign tbl_flat[g*PAGE_W +: PAGE_W] = mem[g];
  end

  assign entry = mem[idx];
endmodule

// File: rtl/pat_index_mux.sv
module pat_index_mux #(
  parameter int IDX_W = 4
) (
  input  logic             win_hit,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [IDX_W-1:0] page_idx,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    if (win_hit) idx = reg_idx;
    else         idx = page_idx;
  end
endmodule

// File: rtl/pat_pin_mux.sv
module pat_pin_mux
  import pat_pkg::*;
#(
  parameter int PHYS_W = 28,
  localparam int PIN_W = PHYS_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  pin_mode_e         mode,
  input  logic [PHYS_W-1:0] phys,
  input  logic [PIN_W-1:0]  ide_addr,
  output logic [PIN_W-1:0]  pins
);
  logic [PIN_W-1:0] pins_q, pins_d, src;

  always_comb begin
    unique case (mode)
      PIN_ROW:  src = phys[PHYS_W-1 -: PIN_W];
      PIN_COL:  src = phys[PIN_W-1:0];
      PIN_IDE:  src = ide_addr;
      default:  src = '0;
    endcase
    pins_d = ld ? src : pins_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end

  assign pins = pins_q;
endmodule

// File: rtl/pat_top.sv
module pat_top
  import pat_pkg::*;
#(
  parameter int            HOST_W    = 16,
  parameter int            DATA_W    = 8,
  parameter int            ENTRY_CNT = 16,
  parameter int            OFF_W     = 12,
  parameter logic [15:0]   WIN_BASE  = 16'hFF00,
  localparam int IDX_W   = $clog2(ENTRY_CNT),
  localparam int PAGE_W  = 2 * DATA_W,
  localparam int PHYS_W  = PAGE_W + OFF_W,
  localparam int PIN_W   = PHYS_W / 2,
  localparam int HIT_LSB = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOST_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              pin_ld,
  input  logic [1:0]        pin_mode,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [PIN_W-1:0]  addr_pins
);
  logic                        win_hit;
  logic                        hi_sel;
  logic [IDX_W-1:0]            idx;
  logic [PAGE_W-1:0]           entry;
  logic [ENTRY_CNT*PAGE_W-1:0] tbl_flat;
  logic                        wr_lo, wr_hi;

  assign win_hit = (host_addr[HOST_W-1:HIT_LSB] == WIN_BASE[HOST_W-1:HIT_LSB]);
  assign hi_sel  = host_addr[0];
  assign wr_lo   = host_wr && win_hit && !hi_sel;
  assign wr_hi   = host_wr && win_hit && hi_sel;

  pat_index_mux #(.IDX_W(IDX_W)) u_idx (
    .win_hit  (win_hit),
    .reg_idx  (host_addr[IDX_W:1]),
    .page_idx (host_addr[HOST_W-1 -: IDX_W]),
    .idx      (idx)
  );

  pat_map_table #(.ENTRY_CNT(ENTRY_CNT), .DATA_W(DATA_W)) u_tbl (
    .clk      (clk),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .idx      (idx),
    .wdata    (host_wdata),
    .entry    (entry),
    .tbl_flat (tbl_flat)
  );

  always_comb begin
    host_rdata = '0;
    if (host_rd && win_hit)
      host_rdata = hi_sel ? entry[PAGE_W-1:DATA_W] : entry[DATA_W-1:0];
  end

  assign phys_addr = {entry, host_addr[OFF_W-1:0]};

  pat_pin_mux #(.PHYS_W(PHYS_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (pin_ld),
    .mode     (pin_mode_e'(pin_mode)),
    .phys     (phys_addr),
    .ide_addr (host_addr[PIN_W-1:0]),
    .pins     (addr_pins)
  );
endmodule

// File: rtl/pat_top_checker.sv
module pat_top_checker #(
  parameter int          HOST_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          ENTRY_CNT = 16,
  parameter int          OFF_W     = 12,
  parameter logic [15:0] WIN_BASE  = 16'hFF00,
  localparam int IDX_W   = $clog2(ENTRY_CNT),
  localparam int PAGE_W  = 2 * DATA_W,
  localparam int PHYS_W  = PAGE_W + OFF_W,
  localparam int PIN_W   = PHYS_W / 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [HOST_W-1:0]           host_addr,
  input logic                        host_wr,
  input logic [DATA_W-1:0]           host_wdata,
  input logic                        host_rd,
  input logic [DATA_W-1:0]           host_rdata,
  input logic                        pin_ld,
  input logic [1:0]                  pin_mode,
  input logic [PHYS_W-1:0]           phys_addr,
  input logic [PIN_W-1:0]            addr_pins,
  input logic [ENTRY_CNT*PAGE_W-1:0] tbl_flat
);
  logic               in_win;
  logic               wr_q, hi_q;
  logic [IDX_W-1:0]   idx_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  landed;

  assign in_win = (host_addr >= WIN_BASE) && (host_addr < WIN_BASE + HOST_W'(2*ENTRY_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0; hi_q <= 1'b0; idx_q <= '0; data_q <= '0;
    end else begin
      wr_q   <= host_wr && in_win;
      hi_q   <= host_addr[0];
      idx_q  <= host_addr[IDX_W:1];
      data_q <= host_wdata;
    end
  end

  assign landed = tbl_flat[int'(idx_q)*PAGE_W + (hi_q ? DATA_W : 0) +: DATA_W];

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> landed == data_q);
  a_r4_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !in_win) |=> $stable(tbl_flat));
  a_r5_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && in_win) |-> host_rdata == '0);
  a_r8_row_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ld && pin_mode == 2'd0) |=> addr_pins == $past(phys_addr[PHYS_W-1 -: PIN_W]));
  a_r8_col_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ld && pin_mode == 2'd1) |=> addr_pins == $past(phys_addr[PIN_W-1:0]));
  a_r9_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ld && pin_mode == 2'd3) |=> addr_pins == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ld |=> $stable(addr_pins));
endmodule

bind pat_top pat_top_checker #(
  .HOST_W(HOST_W), .DATA_W(DATA_W), .ENTRY_CNT(ENTRY_CNT),
  .OFF_W(OFF_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
  .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
  .pin_ld(pin_ld), .pin_mode(pin_mode), .phys_addr(phys_addr),
  .addr_pins(addr_pins), .tbl_flat(tbl_flat)
);

// File: tb/pat_top_test.sv
module pat_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] host_addr;
  logic        host_wr;
  logic [7:0]  host_wdata;
  logic        host_rd;
  logic [7:0]  host_rdata;
  logic        pin_ld;
  logic [1:0]  pin_mode;
  logic [27:0] phys_addr;
  logic [13:0] addr_pins;

  int runs = 0;
  int fails = 0;
  logic [15:0] model [16];

  always #4 clk = ~clk;

  pat_top uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .pin_ld(pin_ld), .pin_mode(pin_mode), .phys_addr(phys_addr),
    .addr_pins(addr_pins)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 check(req, 32'(host_rdata), 32'(exp));
    host_rd = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(16'h5A00 ^ (16'h0F01 * (i + 1)));
  endfunction

  task automatic t_reset;
    check("R10 reset pins", 32'(addr_pins), 32'h0);
  endtask

  task automatic t_fill_readback;
    for (int i = 0; i < 16; i++) begin
      model[i] = pat(i);
      wr_byte(16'hFF00 + 16'(2*i), model[i][7:0]);
      wr_byte(16'hFF01 + 16'(2*i), model[i][15:8]);
    end
    for (int i = 0; i < 16; i++) begin
      rd_check("R1 R3 low byte", 16'hFF00 + 16'(2*i), model[i][7:0]);
      rd_check("R1 R3 high byte", 16'hFF01 + 16'(2*i), model[i][15:8]);
    end
  endtask

  task automatic t_byte_independent;
    wr_byte(16'hFF0A, 8'hE7);
    model[5][7:0] = 8'hE7;
    rd_check("R2 low written", 16'hFF0A, 8'hE7);
    rd_check("R2 high kept", 16'hFF0B, model[5][15:8]);
    wr_byte(16'hFF1F, 8'h3D);
    model[15][15:8] = 8'h3D;
    rd_check("R2 high written", 16'hFF1F, 8'h3D);
    rd_check("R2 low kept", 16'hFF1E, model[15][7:0]);
  endtask

  task automatic t_outside_write;
    wr_byte(16'hFF20, 8'h11);
    wr_byte(16'hFEFF, 8'h22);
    wr_byte(16'h0000, 8'h33);
    wr_byte(16'h7F03, 8'h44);
    rd_check("R4 entry0 low", 16'hFF00, model[0][7:0]);
    rd_check("R4 entry15 high", 16'hFF1F, model[15][15:8]);
    rd_check("R4 entry1 high", 16'hFF03, model[1][15:8]);
    rd_check("R4 entry0 high", 16'hFF01, model[0][15:8]);
  endtask

  task automatic t_rd_quiet;
    @(negedge clk);
    host_addr = 16'hFF04; host_rd = 1'b0;
    #1 check("R5 rd low", 32'(host_rdata), 32'h0);
    host_addr = 16'hFF20; host_rd = 1'b1;
    #1 check("R5 outside window", 32'(host_rdata), 32'h0);
    host_rd = 1'b0;
  endtask

  task automatic t_translate;
    logic [15:0] addrs [4] = '{16'h3ABC, 16'h0000, 16'hF123, 16'h9FFF};
    foreach (addrs[k]) begin
      @(negedge clk);
      host_addr = addrs[k];
      #1 check("R6 translate", 32'(phys_addr), 32'({model[addrs[k][15:12]], addrs[k][11:0]}));
    end
  endtask

  task automatic t_window_index;
    @(negedge clk);
    host_addr = 16'hFF0B;
    #1 check("R7 window index", 32'(phys_addr), 32'({model[5], 12'hF0B}));
  endtask

  task automatic t_pins;
    logic [27:0] p;
    @(negedge clk);
    host_addr = 16'h6C35; pin_mode = 2'd0; pin_ld = 1'b1;
    #1 p = {model[6], 12'hC35};
    @(negedge clk);
    check("R8 row", 32'(addr_pins), 32'(p[27:14]));
    pin_mode = 2'd1;
    @(negedge clk);
    check("R8 col", 32'(addr_pins), 32'(p[13:0]));
    pin_mode = 2'd2; host_addr = 16'hB1F7;
    @(negedge clk);
    check("R9 ide", 32'(addr_pins), 32'h31F7);
    pin_ld = 1'b0; pin_mode = 2'd3; host_addr = 16'h2222;
    @(negedge clk);
    @(negedge clk);
    check("R10 hold", 32'(addr_pins), 32'h31F7);
    pin_ld = 1'b1;
    @(negedge clk);
    check("R9 zero", 32'(addr_pins), 32'h0);
    pin_ld = 1'b0;
  endtask

  initial begin
    #400000;
    fails++; runs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_wdata = '0;
    host_rd = 1'b0; pin_ld = 1'b0; pin_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_readback();
    t_byte_independent();
    t_outside_write();
    t_rd_quiet();
    t_translate();
    t_window_index();
    t_pins();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule